// File: doc/BRIEF.md
# Bit-Sliced Integer ALU with Signed Compare

This block is a two-operand integer arithmetic and logic unit made by repeating one single-bit cell across the word. Every cell holds a full adder, a bitwise AND and a bitwise OR, and picks one of them through a small multiplexer. A three-bit operation code selects the function. Its top bit is a negate control that inverts operand b in every cell and also feeds the carry into the lowest cell, so the adder that adds also subtracts.

The most significant cell produces a signed "less than" indication. It takes the sign of a minus b and corrects it with the signed overflow of that subtraction. This indication goes back to the compare input of the lowest cell, and every other cell's compare input is held at zero. The compare operation therefore returns the value 0 or 1. The result, a zero flag and a signed overflow flag are registered once at the block's edge, which suits a pipelined datapath. The zero flag together with subtraction gives an equality test.

Top module: `alu_bitsliced`

## Requirements
- R1: Operation code 3'b000 gives the bitwise AND of a and b.
- R2: Operation code 3'b001 gives the bitwise OR of a and b.
- R3: Operation code 3'b010 gives a plus b, modulo 2 to the power WIDTH.
- R4: Operation code 3'b110 gives a minus b, modulo 2 to the power WIDTH.
- R5: Operation code 3'b111 gives 1 in bit 0 when a is less than b as two's-complement numbers and 0 otherwise, with all upper result bits 0. The answer stays correct when a minus b overflows.
- R6: For codes 3'b010 and 3'b110, the overflow flag is 1 exactly when the true signed sum or difference falls outside the WIDTH-bit two's-complement range.
- R7: For codes 3'b000, 3'b001 and 3'b111, the overflow flag is 0.
- R8: The zero flag is 1 exactly when every bit of the registered result is 0, so subtracting equal operands raises it.
- R9: The outputs reflect the inputs sampled at the previous rising clock edge. While the synchronous active-high reset is held, the result is 0, zero is 1 and overflow is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| op_i | input | 3 | Operation code: bit 2 is negate, bits 1:0 select AND, OR, sum or compare |
| result_o | output | WIDTH | Registered result |
| zero_o | output | 1 | Registered flag, high when result is all zeros |
| overflow_o | output | 1 | Registered signed overflow for add and subtract, 0 otherwise |

## Verification
The bound checker checks several things on every cycle after reset. It checks that the zero flag agrees with the result. It checks that AND, OR, add and subtract results match the operands from the previous cycle. It checks that overflow stays low for logic and compare codes, and that compare results never set an upper bit. Two behaviours depend on signed range arithmetic and show up only in the bench's scenarios. One is whether overflow fires at exactly the right operand pairs. The other is whether the compare gives the right answer when the internal subtraction wraps. The bench covers them with an exhaustive sweep of a 4-bit instance and directed extreme values on a 32-bit instance, together with the reset values and the one-cycle latency.

// File: rtl/alu_bs_pkg.sv
package alu_bs_pkg;

  // Low two bits of the operation code: result multiplexer select
  typedef enum logic [1:0] {
    SEL_AND  = 2'b00,
    SEL_OR   = 2'b01,
    SEL_SUM  = 2'b10,
    SEL_LESS = 2'b11
  } sel_e;

  function automatic logic fa_sum(input logic x, input logic y, input logic c);
    return x ^ y ^ c;
  endfunction

  function automatic logic fa_carry(input logic x, input logic y, input logic c);
    return (x & y) | (x & c) | (y & c);
  endfunction

  function automatic logic pick(input sel_e s, input logic x, input logic y,
                                input logic sum, input logic less);
    logic r;
    unique case (s)
      SEL_AND:  r = x & y;
      SEL_OR:   r = x | y;
      SEL_SUM:  r = sum;
      default:  r = less;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/alu_bs_slice.sv
module alu_bs_slice
  import alu_bs_pkg::*;
(
  input  logic a_i,
  input  logic b_i,
  input  logic cin_i,
  input  logic less_i,
  input  logic neg_i,
  input  sel_e sel_i,
  output logic res_o,
  output logic cout_o
);

  logic b_eff;
  logic sum;

  assign b_eff  = b_i ^ neg_i;
  assign sum    = fa_sum(a_i, b_eff, cin_i);
  assign cout_o = fa_carry(a_i, b_eff, cin_i);
  assign res_o  = pick(sel_i, a_i, b_eff, sum, less_i);

endmodule

// File: rtl/alu_bs_msb_slice.sv
module alu_bs_msb_slice
  import alu_bs_pkg::*;
(
  input  logic a_i,
  input  logic b_i,
  input  logic cin_i,
  input  logic less_i,
  input  logic neg_i,
  input  sel_e sel_i,
  output logic res_o,
  output logic set_o,
  output logic ovf_o
);

  logic b_eff;
  logic sum;
  logic cout;

  assign b_eff = b_i ^ neg_i;
  assign sum   = fa_sum(a_i, b_eff, cin_i);
  assign cout  = fa_carry(a_i, b_eff, cin_i);
  // Signed overflow: carry entering the sign cell differs from carry leaving it
  assign ovf_o = cin_i ^ cout;
  // Sign of the true difference, corrected when the subtraction wraps
  assign set_o = sum ^ ovf_o;
  assign res_o = pick(sel_i, a_i, b_eff, sum, less_i);

endmodule

// File: rtl/alu_bs_core.sv
module alu_bs_core
  import alu_bs_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             neg_i,
  input  sel_e             sel_i,
  output logic [WIDTH-1:0] res_o,
  output logic             ovf_o
);

  localparam int MSB = WIDTH - 1;

  logic [MSB:0] carry;
  logic         set_w;

  // The negate control is also the carry into the lowest cell
  assign carry[0] = neg_i;

  genvar i;
  generate
    for (i = 0; i < MSB; i++) begin : g_slice
      logic less_w;
      if (i == 0) begin : g_lsb
        assign less_w = set_w;
      end else begin : g_mid
        assign less_w = 1'b0;
      end
      alu_bs_slice u_slice (
        .a_i    (a_i[i]),
        .b_i    (b_i[i]),
        .cin_i  (carry[i]),
        .less_i (less_w),
        .neg_i  (neg_i),
        .sel_i  (sel_i),
        .res_o  (res_o[i]),
        .cout_o (carry[i+1])
      );
    end
  endgenerate

  alu_bs_msb_slice u_msb (
    .a_i    (a_i[MSB]),
    .b_i    (b_i[MSB]),
    .cin_i  (carry[MSB]),
    .less_i (1'b0),
    .neg_i  (neg_i),
    .sel_i  (sel_i),
    .res_o  (res_o[MSB]),
    .set_o  (set_w),
    .ovf_o  (ovf_o)
  );

endmodule

// File: rtl/alu_bitsliced.sv
module alu_bitsliced
  import alu_bs_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [2:0]       op_i,
  output logic [WIDTH-1:0] result_o,
  output logic             zero_o,
  output logic             overflow_o
);

  localparam int OP_NEG_BIT = 2;

  sel_e             sel;
  logic             neg;
  logic [WIDTH-1:0] res_c;
  logic             ovf_raw;

  assign neg = op_i[OP_NEG_BIT];
  assign sel = sel_e'(op_i[1:0]);

  alu_bs_core #(.WIDTH(WIDTH)) u_core (
    .a_i   (a_i),
    .b_i   (b_i),
    .neg_i (neg),
    .sel_i (sel),
    .res_o (res_c),
    .ovf_o (ovf_raw)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result_o   <= '0;
      zero_o     <= 1'b1;
      overflow_o <= 1'b0;
    end else begin
      result_o   <= res_c;
      zero_o     <= ~|res_c;
      overflow_o <= ovf_raw & (sel == SEL_SUM);
    end
  end

endmodule

// File: rtl/alu_bitsliced_chk.sv
module alu_bitsliced_chk #(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rst,
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic [2:0]       op_i,
  input logic [WIDTH-1:0] result_o,
  input logic             zero_o,
  input logic             overflow_o
);

  logic primed = 1'b0;
  always_ff @(posedge clk) primed <= !rst;

  assert_zero_flag_R8: assert property (@(posedge clk) disable iff (rst)
    primed |-> (zero_o == (result_o == '0)));

  assert_and_R1: assert property (@(posedge clk) disable iff (rst)
    primed && $past(op_i) == 3'b000 |-> result_o == ($past(a_i) & $past(b_i)));

  assert_or_R2: assert property (@(posedge clk) disable iff (rst)
    primed && $past(op_i) == 3'b001 |-> result_o == ($past(a_i) | $past(b_i)));

  assert_add_R3: assert property (@(posedge clk) disable iff (rst)
    primed && $past(op_i) == 3'b010 |-> result_o == WIDTH'($past(a_i) + $past(b_i)));

  assert_sub_R4: assert property (@(posedge clk) disable iff (rst)
    primed && $past(op_i) == 3'b110 |-> result_o == WIDTH'($past(a_i) - $past(b_i)));

  assert_slt_upper_R5: assert property (@(posedge clk) disable iff (rst)
    primed && $past(op_i) == 3'b111 |-> result_o[WIDTH-1:1] == '0);

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
    primed && $past(op_i[1:0]) != 2'b10 |-> !overflow_o);

endmodule

bind alu_bitsliced alu_bitsliced_chk #(.WIDTH(WIDTH)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .a_i        (a_i),
  .b_i        (b_i),
  .op_i       (op_i),
  .result_o   (result_o),
  .zero_o     (zero_o),
  .overflow_o (overflow_o)
);

// File: tb/alu_bitsliced_tb.sv
module alu_bitsliced_tb;

  localparam int NW = 4;
  localparam int WW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [2:0]    op  = 3'b000;
  logic [NW-1:0] a4  = '0, b4 = '0;
  logic [WW-1:0] a32 = '0, b32 = '0;
  logic [NW-1:0] r4;
  logic [WW-1:0] r32;
  logic          z4, v4, z32, v32;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  alu_bitsliced #(.WIDTH(NW)) u_dut (
    .clk(clk), .rst(rst), .a_i(a4), .b_i(b4), .op_i(op),
    .result_o(r4), .zero_o(z4), .overflow_o(v4)
  );

  alu_bitsliced #(.WIDTH(WW)) u_dut_wide (
    .clk(clk), .rst(rst), .a_i(a32), .b_i(b32), .op_i(op),
    .result_o(r32), .zero_o(z32), .overflow_o(v32)
  );

  task automatic check(input string req, input longint act, input longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s op=%b actual=%0h expected=%0h", req, op, act, exp);
    end
  endtask

  // Expected outputs from signed/unsigned arithmetic on w-bit values
  task automatic model(input int w, input longint a, input longint b, input logic [2:0] o,
                       output longint res, output longint z, output longint v);
    longint mask, sa, sb, s, lo, hi;
    mask = (longint'(1) << w) - 1;
    sa = (a >= (longint'(1) << (w-1))) ? a - (longint'(1) << w) : a;
    sb = (b >= (longint'(1) << (w-1))) ? b - (longint'(1) << w) : b;
    hi = (longint'(1) << (w-1)) - 1;
    lo = -(longint'(1) << (w-1));
    v = 0;
    case (o)
      3'b000: res = a & b;
      3'b001: res = a | b;
      3'b010: begin res = (a + b) & mask; s = sa + sb; v = (s > hi || s < lo) ? 1 : 0; end
      3'b110: begin res = (a - b) & mask; s = sa - sb; v = (s > hi || s < lo) ? 1 : 0; end
      default: res = (sa < sb) ? 1 : 0;
    endcase
    z = (res == 0) ? 1 : 0;
  endtask

  function automatic string tag(input logic [2:0] o);
    case (o)
      3'b000: return "R1";
      3'b001: return "R2";
      3'b010: return "R3";
      3'b110: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic wide(input logic [2:0] o, input logic [WW-1:0] a, input logic [WW-1:0] b);
    longint er, ez, ev;
    op = o; a32 = a; b32 = b;
    @(negedge clk);
    model(WW, longint'(a), longint'(b), o, er, ez, ev);
    check(tag(o), longint'(r32), er);
    check("R8", longint'(z32), ez);
    check((o[1:0] == 2'b10) ? "R6" : "R7", longint'(v32), ev);
  endtask

  initial begin
    logic [2:0] ops [5];
    ops[0] = 3'b000; ops[1] = 3'b001; ops[2] = 3'b010; ops[3] = 3'b110; ops[4] = 3'b111;

    // Reset state with active inputs (R9)
    op = 3'b010; a32 = '1; b32 = 32'd5; a4 = 4'hF; b4 = 4'h3;
    repeat (3) @(negedge clk);
    check("R9", longint'(r32), 0);
    check("R9", longint'(z32), 1);
    check("R9", longint'(v32), 0);
    check("R9", longint'(r4), 0);
    rst = 1'b0;
    @(negedge clk);
    // One-cycle latency: sum of inputs held across the release (R9)
    check("R9", longint'(r32), 64'd4);
    check("R9", longint'(r4), 64'd2);

    // Exhaustive sweep on the narrow instance
    for (int k = 0; k < 5; k++) begin
      for (int a = 0; a < (1 << NW); a++) begin
        for (int b = 0; b < (1 << NW); b++) begin
          longint er, ez, ev;
          op = ops[k]; a4 = NW'(a); b4 = NW'(b);
          @(negedge clk);
          model(NW, longint'(a), longint'(b), ops[k], er, ez, ev);
          check(tag(ops[k]), longint'(r4), er);
          check("R8", longint'(z4), ez);
          check((ops[k][1:0] == 2'b10) ? "R6" : "R7", longint'(v4), ev);
        end
      end
    end

    // Directed extremes on the wide instance
    wide(3'b000, 32'hF0F0_A5A5, 32'h0FF0_FFFF);             // R1
    wide(3'b001, 32'h8000_0001, 32'h0000_F000);             // R2
    wide(3'b010, 32'h7FFF_FFFF, 32'h0000_0001);             // R3, R6 positive overflow
    wide(3'b010, 32'h8000_0000, 32'h8000_0000);             // R6 negative overflow, R8 zero
    wide(3'b010, 32'hFFFF_FFFF, 32'h0000_0001);             // R3 carry out, no overflow
    wide(3'b110, 32'h8000_0000, 32'h0000_0001);             // R4, R6
    wide(3'b110, 32'h1234_5678, 32'h1234_5678);             // R8 equality
    wide(3'b111, 32'h7FFF_FFFF, 32'h8000_0000);             // R5 overflowing compare -> 0
    wide(3'b111, 32'h8000_0000, 32'h7FFF_FFFF);             // R5 overflowing compare -> 1
    wide(3'b111, 32'hFFFF_FFFF, 32'h0000_0000);             // R5 -1 < 0
    wide(3'b111, 32'h0000_0005, 32'h0000_0005);             // R5 equal -> 0, R7
    wide(3'b001, 32'h0000_0000, 32'h0000_0000);             // R8 zero on OR

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule